// File: doc/BRIEF.md
# Vector Half-to-Single Splitting Widener

This block executes one vector operation that widens packed 16-bit half-precision values to 32-bit single-precision values and separates them by parity. A source vector of `VLEN` bits holds `VLEN/16` half elements. The converted even-indexed elements fill the first destination vector, and the converted odd-indexed elements fill the second. Both destination vectors are `VLEN` bits wide, so one source register produces a pair of result registers.

A small decoder in front of the datapath checks the 32-bit instruction word. It gives out the source register index combinationally, so a register file can supply the operand in the same cycle. It also works out the even/odd destination register pair. One clock edge later the block presents the write enable, the destination indices, both result vectors and the status outputs. The status outputs are an undefined-instruction indication when a required capability is missing, and a trap when streaming execution is disabled.

Arithmetic behaviour is set by three mode inputs: flush of half-precision subnormals, default-NaN substitution, and an alternative half format with no infinities or NaNs. Invalid-operation and input-denormal events set flags that stay high until reset.

Top module: `hcvt_split_top`

## Requirements
- R1: An instruction is recognised only when `issue_i` is high, bits 31:10 equal `1100000110100000111000` and bit 0 is 1. Any other word, or `issue_i` low, gives `wr_en_o`, `undef_o` and `trap_o` all low on the following cycle.
- R2: `src_idx_o` equals instruction bits 9:5 combinationally. After a write, `dst0_o` is twice bits 4:1 and `dst1_o` is `dst0_o`+1.
- R3: A recognised instruction with `feat_en_i` or `base_en_i` low raises `undef_o` for one cycle, one clock after issue, and `wr_en_o` stays low.
- R4: A recognised instruction with both capabilities present but `stream_en_i` low raises `trap_o` one clock after issue, and `wr_en_o` stays low. With `stream_en_i` high, `wr_en_o` rises one clock after issue.
- R5: On a write, source element 2p (bits 32p+15:32p) converted lands in bits 32p+31:32p of `res0_o`. Element 2p+1 lands in the same lane of `res1_o`. Every lane of both results is written.
- R6: A normal half value keeps its sign, gets exponent field plus 112, and has its 10 fraction bits placed at the top of the 23-bit fraction. Zeros keep their sign.
- R7: With `fz16_i` low, a subnormal half is normalised into an exact normal single value.
- R8: With `fz16_i` high, a subnormal half becomes a zero of the same sign and sets `flag_idc_o`.
- R9: With `ahp_i` low, a half infinity becomes a single infinity of the same sign.
- R10: With `ahp_i` and `dn_i` low, a NaN keeps its sign and payload, with fraction bit 22 forced to 1. A signalling NaN (half fraction bit 9 low) sets `flag_ioc_o`.
- R11: With `dn_i` high and `ahp_i` low, every NaN result is 0x7FC00000. A signalling input still sets `flag_ioc_o`.
- R12: With `ahp_i` high, exponent field 31 is finite: the result exponent is 143, and no flag is raised.
- R13: Result vectors and destination indices hold their values when no write occurs. The two flags are sticky until reset, and reset clears every output register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction word valid this cycle |
| instr_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | Half-to-single multi-vector feature implemented |
| base_en_i | input | 1 | Base matrix-extension level present |
| stream_en_i | input | 1 | Streaming vector execution enabled |
| src_vec_i | input | VLEN | Source vector of packed halves |
| fz16_i | input | 1 | Flush half subnormal inputs to zero |
| dn_i | input | 1 | Default-NaN mode |
| ahp_i | input | 1 | Alternative half format |
| src_idx_o | output | 5 | Source register index, combinational |
| wr_en_o | output | 1 | Destination pair write enable |
| dst0_o | output | 5 | First destination register index |
| dst1_o | output | 5 | Second destination register index |
| res0_o | output | VLEN | Results from even source elements |
| res1_o | output | VLEN | Results from odd source elements |
| undef_o | output | 1 | Undefined instruction |
| trap_o | output | 1 | Streaming-disabled trap |
| flag_ioc_o | output | 1 | Sticky invalid-operation flag |
| flag_idc_o | output | 1 | Sticky input-denormal flag |

## Verification
The bench builds the block with the default `VLEN` of 128, which gives eight half elements and four lanes per result. That is enough for one vector to carry a full set of special values together with ordinary numbers. A misrouted pair index or a parity swap between the two results therefore appears in several lanes at once. The bench also uses odd register fields to show errors in pair arithmetic, and single bit flips in the opcode to show that matching is exact.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

    // Fixed upper opcode bits of the recognised word
    localparam logic [21:0] OPC_HI   = 22'b1100000110100000111000;
    localparam int unsigned HALF_W   = 16;
    localparam int unsigned SINGLE_W = 32;
    localparam logic [31:0] QNAN_DEF = 32'h7FC0_0000;
    // Rebias from half (15) to single (127)
    localparam logic [7:0]  REBIAS   = 8'd112;

    typedef struct packed {
        logic ioc;
        logic idc;
    } fp_evt_t;

endpackage

// File: rtl/hcvt_lane.sv
module hcvt_lane
    import hcvt_pkg::*;
(
    input  logic [HALF_W-1:0]   half_i,
    input  logic                fz16_i,
    input  logic                dn_i,
    input  logic                ahp_i,
    output logic [SINGLE_W-1:0] single_o,
    output fp_evt_t             evt_o
);

    logic       sgn;
    logic [4:0] exp_h;
    logic [9:0] frac_h;
    logic [3:0] lead;
    logic [9:0] norm;
    logic [3:0] shamt;

    assign sgn    = half_i[15];
    assign exp_h  = half_i[14:10];
    assign frac_h = half_i[9:0];

    // Position of the leading one in a subnormal fraction
    always_comb begin
        lead = 4'd0;
        for (int i = 0; i < 10; i++) begin
            if (frac_h[i]) lead = 4'(i);
        end
        shamt = 4'd10 - lead;
        norm  = frac_h << shamt;
    end

    always_comb begin
        single_o  = {sgn, exp_h + REBIAS, frac_h, 13'b0};
        evt_o.ioc = 1'b0;
        evt_o.idc = 1'b0;
        if (exp_h == 5'd31 && !ahp_i) begin
            if (frac_h == 10'd0) begin
                single_o = {sgn, 8'hFF, 23'b0};
            end else begin
                evt_o.ioc = ~frac_h[9];
                if (dn_i) single_o = QNAN_DEF;
                else      single_o = {sgn, 8'hFF, 1'b1, frac_h[8:0], 13'b0};
            end
        end else if (exp_h == 5'd0) begin
            if (frac_h == 10'd0) begin
                single_o = {sgn, 31'b0};
            end else if (fz16_i) begin
                single_o  = {sgn, 31'b0};
                evt_o.idc = 1'b1;
            end else begin
                single_o = {sgn, 8'(lead) + 8'd103, norm, 13'b0};
            end
        end else begin
            single_o = {sgn, 8'(exp_h) + REBIAS, frac_h, 13'b0};
        end
    end

endmodule

// File: rtl/hcvt_decode.sv
module hcvt_decode
    import hcvt_pkg::*;
(
    input  logic        issue_i,
    input  logic [31:0] instr_i,
    input  logic        feat_en_i,
    input  logic        base_en_i,
    input  logic        stream_en_i,
    output logic [4:0]  src_idx_o,
    output logic [4:0]  dst0_o,
    output logic [4:0]  dst1_o,
    output logic        write_o,
    output logic        undef_o,
    output logic        trap_o
);

    logic hit;
    logic caps;

    always_comb begin
        hit       = issue_i && (instr_i[31:10] == OPC_HI) && instr_i[0];
        caps      = feat_en_i && base_en_i;
        src_idx_o = instr_i[9:5];
        dst0_o    = {instr_i[4:1], 1'b0};
        dst1_o    = {instr_i[4:1], 1'b1};
        undef_o   = hit && !caps;
        trap_o    = hit && caps && !stream_en_i;
        write_o   = hit && caps && stream_en_i;
    end

endmodule

// File: rtl/hcvt_split_top.sv
module hcvt_split_top
    import hcvt_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [31:0]     instr_i,
    input  logic            feat_en_i,
    input  logic            base_en_i,
    input  logic            stream_en_i,
    input  logic [VLEN-1:0] src_vec_i,
    input  logic            fz16_i,
    input  logic            dn_i,
    input  logic            ahp_i,
    output logic [4:0]      src_idx_o,
    output logic            wr_en_o,
    output logic [4:0]      dst0_o,
    output logic [4:0]      dst1_o,
    output logic [VLEN-1:0] res0_o,
    output logic [VLEN-1:0] res1_o,
    output logic            undef_o,
    output logic            trap_o,
    output logic            flag_ioc_o,
    output logic            flag_idc_o
);

    localparam int unsigned HALVES = VLEN / HALF_W;
    localparam int unsigned PAIRS  = VLEN / (2 * HALF_W);

    typedef struct packed {
        logic            wr;
        logic            undef;
        logic            trap;
        logic [4:0]      d0;
        logic [4:0]      d1;
        logic [VLEN-1:0] r0;
        logic [VLEN-1:0] r1;
        logic            ioc;
        logic            idc;
    } state_t;

    state_t st_d, st_q;

    logic [4:0] dec_d0, dec_d1;
    logic       dec_wr, dec_undef, dec_trap;

    logic [SINGLE_W-1:0] conv [HALVES];
    fp_evt_t             evt  [HALVES];

    hcvt_decode u_dec (
        .issue_i     (issue_i),
        .instr_i     (instr_i),
        .feat_en_i   (feat_en_i),
        .base_en_i   (base_en_i),
        .stream_en_i (stream_en_i),
        .src_idx_o   (src_idx_o),
        .dst0_o      (dec_d0),
        .dst1_o      (dec_d1),
        .write_o     (dec_wr),
        .undef_o     (dec_undef),
        .trap_o      (dec_trap)
    );

    for (genvar g = 0; g < HALVES; g++) begin : g_lane
        hcvt_lane u_lane (
            .half_i   (src_vec_i[g*HALF_W +: HALF_W]),
            .fz16_i   (fz16_i),
            .dn_i     (dn_i),
            .ahp_i    (ahp_i),
            .single_o (conv[g]),
            .evt_o    (evt[g])
        );
    end

    always_comb begin
        logic any_ioc;
        logic any_idc;
        st_d       = st_q;
        st_d.wr    = dec_wr;
        st_d.undef = dec_undef;
        st_d.trap  = dec_trap;
        any_ioc    = 1'b0;
        any_idc    = 1'b0;
        for (int h = 0; h < HALVES; h++) begin
            any_ioc = any_ioc | evt[h].ioc;
            any_idc = any_idc | evt[h].idc;
        end
        if (dec_wr) begin
            st_d.d0 = dec_d0;
            st_d.d1 = dec_d1;
            for (int p = 0; p < PAIRS; p++) begin
                st_d.r0[p*SINGLE_W +: SINGLE_W] = conv[2*p];
                st_d.r1[p*SINGLE_W +: SINGLE_W] = conv[2*p+1];
            end
            st_d.ioc = st_q.ioc | any_ioc;
            st_d.idc = st_q.idc | any_idc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o    = st_q.wr;
    assign undef_o    = st_q.undef;
    assign trap_o     = st_q.trap;
    assign dst0_o     = st_q.d0;
    assign dst1_o     = st_q.d1;
    assign res0_o     = st_q.r0;
    assign res1_o     = st_q.r1;
    assign flag_ioc_o = st_q.ioc;
    assign flag_idc_o = st_q.idc;

endmodule

// File: rtl/hcvt_split_chk.sv
module hcvt_split_chk #(
    parameter int unsigned VLEN = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_i,
    input logic            feat_en_i,
    input logic            base_en_i,
    input logic            stream_en_i,
    input logic            wr_en_o,
    input logic [4:0]      dst0_o,
    input logic [4:0]      dst1_o,
    input logic [VLEN-1:0] res0_o,
    input logic [VLEN-1:0] res1_o,
    input logic            undef_o,
    input logic            trap_o,
    input logic            flag_ioc_o,
    input logic            flag_idc_o
);

    a_r3_undef_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> !wr_en_o);

    a_r3_undef_cause: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> $past(issue_i && !(feat_en_i && base_en_i)));

    a_r4_write_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(issue_i && feat_en_i && base_en_i && stream_en_i));

    a_r4_trap_alone: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (!wr_en_o && !undef_o && $past(!stream_en_i)));

    a_r2_dst_pair: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (!dst0_o[0] && dst1_o == dst0_o + 5'd1));

    a_r13_ioc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ioc_o |=> flag_ioc_o);

    a_r13_idc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_idc_o |=> flag_idc_o);

    a_r13_hold_res0: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res0_o) |-> wr_en_o);

    a_r13_hold_res1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res1_o) |-> wr_en_o);

endmodule

bind hcvt_split_top hcvt_split_chk #(.VLEN(VLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .feat_en_i   (feat_en_i),
    .base_en_i   (base_en_i),
    .stream_en_i (stream_en_i),
    .wr_en_o     (wr_en_o),
    .dst0_o      (dst0_o),
    .dst1_o      (dst1_o),
    .res0_o      (res0_o),
    .res1_o      (res1_o),
    .undef_o     (undef_o),
    .trap_o      (trap_o),
    .flag_ioc_o  (flag_ioc_o),
    .flag_idc_o  (flag_idc_o)
);

// File: tb/hcvt_split_top_tb.sv
module hcvt_split_top_tb;

    localparam int unsigned VLEN   = 128;
    localparam int unsigned CLK_NS = 10;
    localparam int unsigned NH     = VLEN / 16;
    localparam logic [21:0] OPC    = 22'b1100000110100000111000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_i = 1'b0;
    logic [31:0]     instr_i = '0;
    logic            feat_en_i = 1'b0, base_en_i = 1'b0, stream_en_i = 1'b0;
    logic [VLEN-1:0] src_vec_i = '0;
    logic            fz16_i = 1'b0, dn_i = 1'b0, ahp_i = 1'b0;
    logic [4:0]      src_idx_o, dst0_o, dst1_o;
    logic            wr_en_o, undef_o, trap_o, flag_ioc_o, flag_idc_o;
    logic [VLEN-1:0] res0_o, res1_o;

    int n_run = 0;
    int n_fail = 0;

    // Reference state
    logic [VLEN-1:0] m_r0 = '0, m_r1 = '0;
    logic [4:0]      m_d0 = '0, m_d1 = '0;
    bit              m_ioc = 0, m_idc = 0;

    always #(CLK_NS/2) clk = ~clk;

    hcvt_split_top #(.VLEN(VLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
        .feat_en_i(feat_en_i), .base_en_i(base_en_i), .stream_en_i(stream_en_i),
        .src_vec_i(src_vec_i), .fz16_i(fz16_i), .dn_i(dn_i), .ahp_i(ahp_i),
        .src_idx_o(src_idx_o), .wr_en_o(wr_en_o), .dst0_o(dst0_o), .dst1_o(dst1_o),
        .res0_o(res0_o), .res1_o(res1_o), .undef_o(undef_o), .trap_o(trap_o),
        .flag_ioc_o(flag_ioc_o), .flag_idc_o(flag_idc_o)
    );

    task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Behavioural half -> single widening from the requirement text
    function automatic logic [31:0] ref_cvt(input logic [15:0] h, input bit fz, input bit dn,
                                            input bit ahp, output bit ioc, output bit idc);
        int e, m, ex;
        bit s;
        s = h[15]; e = int'(h[14:10]); m = int'(h[9:0]);
        ioc = 0; idc = 0;
        if (e == 31 && !ahp) begin
            if (m == 0) return {s, 8'hFF, 23'd0};
            ioc = (m < 512);
            if (dn) return 32'h7FC00000;
            return {s, 8'hFF, 23'((m | 512) * 8192)};
        end
        if (e == 0) begin
            if (m == 0) return {s, 31'd0};
            if (fz) begin idc = 1; return {s, 31'd0}; end
            ex = 113;
            while (m < 1024) begin m = m * 2; ex = ex - 1; end
            return {s, 8'(ex), 23'((m - 1024) * 8192)};
        end
        return {s, 8'(e + 112), 23'(m * 8192)};
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] src, input logic [3:0] dd);
        return {OPC, src, dd, 1'b1};
    endfunction

    task automatic op(input logic [31:0] ins, input bit f, input bit b, input bit st,
                      input logic [VLEN-1:0] v, input bit fz, input bit dn, input bit ahp,
                      input string tag);
        bit hit, wr, und, trp, io, id;
        logic [31:0] c;
        @(negedge clk);
        issue_i = 1'b1; instr_i = ins; feat_en_i = f; base_en_i = b; stream_en_i = st;
        src_vec_i = v; fz16_i = fz; dn_i = dn; ahp_i = ahp;
        hit = (ins[31:10] == OPC) && ins[0];
        wr  = hit && f && b && st;
        und = hit && !(f && b);
        trp = hit && f && b && !st;
        if (wr) begin
            m_d0 = 5'(ins[4:1] * 2);
            m_d1 = 5'(ins[4:1] * 2 + 1);
            for (int k = 0; k < NH; k++) begin
                c = ref_cvt(v[k*16 +: 16], fz, dn, ahp, io, id);
                if (io) m_ioc = 1;
                if (id) m_idc = 1;
                if (k % 2 == 0) m_r0[(k/2)*32 +: 32] = c;
                else            m_r1[(k/2)*32 +: 32] = c;
            end
        end
        #1;
        chk("R2 src_idx", VLEN'(src_idx_o), VLEN'(ins[9:5]));
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0;
        chk({"R1/R4 wr_en ", tag}, VLEN'(wr_en_o), VLEN'(wr));
        chk({"R1/R3 undef ", tag}, VLEN'(undef_o), VLEN'(und));
        chk({"R4 trap ", tag}, VLEN'(trap_o), VLEN'(trp));
        chk({"R2 dst0 ", tag}, VLEN'(dst0_o), VLEN'(m_d0));
        chk({"R2 dst1 ", tag}, VLEN'(dst1_o), VLEN'(m_d1));
        chk({"R5 res0 ", tag}, res0_o, m_r0);
        chk({"R5 res1 ", tag}, res1_o, m_r1);
        chk({"R13 ioc ", tag}, VLEN'(flag_ioc_o), VLEN'(m_ioc));
        chk({"R13 idc ", tag}, VLEN'(flag_idc_o), VLEN'(m_idc));
    endtask

    function automatic logic [VLEN-1:0] pack8(input logic [15:0] a0, a1, a2, a3, a4, a5, a6, a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] spec;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state R13
        chk("R13 reset wr", VLEN'(wr_en_o), '0);
        chk("R13 reset res0", res0_o, '0);
        chk("R13 reset res1", res1_o, '0);
        chk("R13 reset flags", VLEN'({flag_ioc_o, flag_idc_o, undef_o, trap_o}), '0);

        // R6 normal values and signed zeros
        op(mk(5'd3, 4'd5), 1, 1, 1,
           pack8(16'h3C00, 16'hBC00, 16'h0000, 16'h8000, 16'h7BFF, 16'h0400, 16'h3555, 16'hC000),
           0, 0, 0, "R6 normal");
        // R7 subnormals normalised
        op(mk(5'd17, 4'd15), 1, 1, 1,
           pack8(16'h0001, 16'h83FF, 16'h0200, 16'h8155, 16'h03FF, 16'h0000, 16'h0010, 16'h3C00),
           0, 0, 0, "R7 subnormal");
        // R8 flush subnormals
        op(mk(5'd31, 4'd0), 1, 1, 1,
           pack8(16'h0001, 16'h83FF, 16'h0200, 16'h8155, 16'h03FF, 16'h0000, 16'h0010, 16'h3C00),
           1, 0, 0, "R8 flush");
        spec = pack8(16'h7C00, 16'hFC00, 16'h7E00, 16'h7E3F, 16'hFE01, 16'h3C00, 16'h0001, 16'h4000);
        // R9 infinities, R10 quiet NaNs only (no ioc)
        op(mk(5'd1, 4'd7), 1, 1, 1, spec, 0, 0, 0, "R9/R10 inf qnan");
        // R10 signalling NaNs quieted
        op(mk(5'd2, 4'd8), 1, 1, 1,
           pack8(16'h7D00, 16'hFC01, 16'h7E00, 16'h7C00, 16'h7DFF, 16'h3C00, 16'h0000, 16'h8000),
           0, 0, 0, "R10 snan");
        // R11 default NaN
        op(mk(5'd4, 4'd9), 1, 1, 1,
           pack8(16'h7D00, 16'hFE01, 16'h7E00, 16'hFC00, 16'h7C01, 16'h3C00, 16'h0000, 16'h8000),
           0, 1, 0, "R11 default nan");
        // R12 alternative half format
        op(mk(5'd6, 4'd11), 1, 1, 1,
           pack8(16'h7C00, 16'hFC00, 16'h7E00, 16'h7D00, 16'hFFFF, 16'h3C00, 16'h0000, 16'h7C01),
           0, 1, 1, "R12 ahp");

        // R3 undefined without capability; results held (R13)
        op(mk(5'd9, 4'd3), 0, 1, 1, ~spec, 0, 0, 0, "R3 no feat");
        op(mk(5'd9, 4'd3), 1, 0, 1, ~spec, 0, 0, 0, "R3 no base");
        // R4 trap when streaming disabled
        op(mk(5'd9, 4'd3), 1, 1, 0, ~spec, 0, 0, 0, "R4 no stream");
        // R1 non-matching words and idle issue
        op({OPC, 5'd9, 4'd3, 1'b0}, 1, 1, 1, ~spec, 0, 0, 0, "R1 bit0 low");
        op(mk(5'd9, 4'd3) ^ 32'h0000_0400, 1, 1, 1, ~spec, 0, 0, 0, "R1 bit10 flip");
        op(mk(5'd9, 4'd3) ^ 32'h8000_0000, 1, 1, 1, ~spec, 0, 0, 0, "R1 bit31 flip");
        @(negedge clk);
        issue_i = 1'b0; instr_i = mk(5'd9, 4'd3);
        @(posedge clk);
        @(negedge clk);
        chk("R1 issue low wr", VLEN'(wr_en_o), '0);
        chk("R13 issue low hold", res0_o, m_r0);

        // R5 random vectors and modes
        for (int i = 0; i < 40; i++) begin
            logic [VLEN-1:0] rv;
            for (int w = 0; w < VLEN / 32; w++) rv[w*32 +: 32] = $urandom;
            op(mk(5'($urandom), 4'($urandom)), 1, 1, 1, rv,
               bit'($urandom), bit'($urandom), bit'($urandom % 4 == 0), "R5 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule